// File: doc/BRIEF.md
# Serial Control Register Port

This block is a four-wire serial slave that lets a host processor program a bank of control registers and read back both those registers and a set of status values, such as peak levels. The host frames each transaction with an active-low select line (`ss_n`) and shifts a fixed 16-bit word in on `mosi`. The serial clock runs without pause and has no phase relation to the audio clock. For that reason a frame is delimited only by the select line, never by gaps in the clock.

Each accepted write is first stored in a serial-side shadow copy. It is then passed into the audio clock domain through a toggle handshake, and there it updates the register that drives the datapath. After reset, an initialisation window of a fixed number of audio frame ticks blocks all writes. Any write that arrives during this window is discarded and sets a sticky error flag. Reads are served at any time. Control addresses return the shadow copy. Status addresses return the status inputs after they pass through synchronisers into the serial domain.

Top module: `serctl_port`

## Requirements
- R1: While reset is low, and after it is released, control register k holds the default value k*64+3. `init_busy` is 1 and `wr_err` is 0 until an event described below changes them.
- R2: A frame is 16 bits, sent MSB first and sampled on rising `sclk` while `ss_n` is low. Bits 15:12 carry the register address. Bit 11 selects read (1) or write (0). Bit 10 is reserved and has no effect. Bits 9:0 carry the data.
- R3: A write frame to control address 0..NCTRL-1, completed after the window ends, sets the `ctrl_o` slice [k*10 +: 10] of that address to the data field. All other slices are left unchanged.
- R4: In a read frame, `miso` presents the addressed 10-bit value MSB first in frame bit positions 6..15, changing on falling `sclk`. In positions 0..5, and whenever `ss_n` is high, `miso` is 0.
- R5: A read of address NCTRL+j returns the status slice `stat_i[j*10 +: 10]`.
- R6: A write to a status address (NCTRL..15) changes no control output and no status read value.
- R7: `init_busy` falls to 0 on the audio clock edge that counts the INIT_FRAMES-th `frame_tick` pulse after reset, and then stays low.
- R8: A write frame completed while the window is still seen as active is dropped with no effect on `ctrl_o`. It sets `wr_err`, which then stays at 1 until reset.
- R9: A frame cut short by `ss_n` rising before the 16th bit has no effect. Bits clocked in after the 16th bit of a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Audio-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| frame_tick | input | 1 | One-cycle pulse per audio frame, synchronous to `aclk` |
| stat_i | input | NSTAT*10 | Status values, one 10-bit slice per status address |
| ctrl_o | output | NCTRL*10 | Control registers in the audio domain, one 10-bit slice each |
| init_busy | output | 1 | High while the post-reset write-blocking window is active |
| sclk | input | 1 | Continuously running serial clock |
| ss_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial read data to host |
| wr_err | output | 1 | Sticky flag for writes dropped by the port (serial domain) |

## Verification
The properties assume the following about the inputs. `ss_n` changes only while `sclk` is low. `frame_tick` is a single-cycle pulse in the audio domain. Each write frame is followed by enough idle serial cycles for the toggle hand-off to return its acknowledge before the next frame completes. The bench respects all three. It drives `ss_n` and `mosi` only on falling `sclk` edges, pulses `frame_tick` for exactly one `aclk` cycle, and leaves four idle serial cycles after every frame. It also loads `stat_i` several serial cycles before any read that depends on it, so the synchronised status copy is stable when it is shifted out.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned DATA_W     = 10;
  localparam int unsigned HDR_W      = ADDR_W + 1;        // address plus read flag
  localparam int unsigned DATA_START = WORD_W - DATA_W;   // first data bit position
  localparam int unsigned CNT_W      = $clog2(WORD_W + 1);
  localparam int unsigned DIDX_W     = $clog2(DATA_W);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  function automatic addr_t word_addr(word_t w);
    return w[WORD_W-1 -: ADDR_W];
  endfunction

  function automatic logic word_is_read(word_t w);
    return w[WORD_W-1-ADDR_W];
  endfunction

  function automatic data_t word_data(word_t w);
    return w[DATA_W-1:0];
  endfunction

  function automatic data_t ctl_default(int unsigned idx);
    return data_t'(idx * 64 + 3);
  endfunction

  function automatic logic in_data_window(logic [CNT_W-1:0] cnt);
    return (32'(cnt) >= DATA_START) && (32'(cnt) < WORD_W);
  endfunction

  function automatic logic [DIDX_W-1:0] data_bit(logic [CNT_W-1:0] cnt);
    return DIDX_W'(WORD_W - 1 - 32'(cnt));
  endfunction
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {W{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/serctl_rx.sv
module serctl_rx
  import serctl_pkg::*;
(
  input  logic  sclk,
  input  logic  rst_n,
  input  logic  ss_n,
  input  logic  mosi,
  input  data_t rdata,
  output addr_t hdr_addr,
  output logic  hdr_rd,
  output logic  done,
  output word_t word,
  output logic  miso
);
  logic [CNT_W-1:0] cnt;
  word_t            sh;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sh       <= '0;
      hdr_addr <= '0;
      hdr_rd   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= !ss_n && (32'(cnt) == WORD_W - 1);
      if (ss_n) begin
        cnt <= '0;
      end else if (32'(cnt) != WORD_W) begin
        sh  <= {sh[WORD_W-2:0], mosi};
        cnt <= cnt + 1'b1;
        if (32'(cnt) == HDR_W - 1) {hdr_addr, hdr_rd} <= {sh[ADDR_W-1:0], mosi};
      end
    end
  end

  assign word = sh;

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) miso <= 1'b0;
    else        miso <= (!ss_n && hdr_rd && in_data_window(cnt)) ? rdata[data_bit(cnt)] : 1'b0;
  end
endmodule

// File: rtl/serctl_xfer.sv
module serctl_xfer
  import serctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic  s_clk,
  input  logic  a_clk,
  input  logic  rst_n,
  input  logic  s_push,
  input  addr_t s_addr,
  input  data_t s_data,
  output logic  s_busy,
  output logic  a_upd,
  output addr_t a_addr,
  output data_t a_data
);
  logic  req, req_a, ack, ack_s;
  addr_t hold_addr;
  data_t hold_data;

  always_ff @(posedge s_clk or negedge rst_n) begin
    if (!rst_n) begin
      req       <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else if (s_push) begin
      req       <= ~req;
      hold_addr <= s_addr;
      hold_data <= s_data;
    end
  end

  serctl_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_req_sync (
    .clk(a_clk), .rst_n(rst_n), .d(req), .q(req_a));

  always_ff @(posedge a_clk or negedge rst_n) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= req_a;
  end

  assign a_upd  = req_a ^ ack;
  assign a_addr = hold_addr;
  assign a_data = hold_data;

  serctl_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_ack_sync (
    .clk(s_clk), .rst_n(rst_n), .d(ack), .q(ack_s));

  assign s_busy = req ^ ack_s;
endmodule

// File: rtl/serctl_initwin.sv
module serctl_initwin #(
  parameter int unsigned INIT_FRAMES = 20
) (
  input  logic aclk,
  input  logic rst_n,
  input  logic frame_tick,
  output logic busy
);
  localparam int unsigned IW = $clog2(INIT_FRAMES + 1);
  logic [IW-1:0] cnt;

  assign busy = (32'(cnt) != INIT_FRAMES);

  always_ff @(posedge aclk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (frame_tick && busy) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/serctl_port.sv
module serctl_port
  import serctl_pkg::*;
#(
  parameter int unsigned NCTRL       = 12,
  parameter int unsigned INIT_FRAMES = 20,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NSTAT      = (1 << ADDR_W) - NCTRL
) (
  input  logic                    aclk,
  input  logic                    rst_n,
  input  logic                    frame_tick,
  input  logic [NSTAT*DATA_W-1:0] stat_i,
  output logic [NCTRL*DATA_W-1:0] ctrl_o,
  output logic                    init_busy,
  input  logic                    sclk,
  input  logic                    ss_n,
  input  logic                    mosi,
  output logic                    miso,
  output logic                    wr_err
);
  addr_t hdr_addr, w_addr, a_addr;
  logic  hdr_rd, rx_done, s_init, s_busy, wr_req, wr_ctl, s_drop, s_push, a_upd;
  word_t rx_word;
  data_t rdata, a_data;
  data_t shadow [NCTRL];
  data_t creg   [NCTRL];
  logic [NSTAT*DATA_W-1:0] stat_s;

  serctl_rx i_rx (
    .sclk(sclk), .rst_n(rst_n), .ss_n(ss_n), .mosi(mosi), .rdata(rdata),
    .hdr_addr(hdr_addr), .hdr_rd(hdr_rd), .done(rx_done), .word(rx_word), .miso(miso));

  serctl_initwin #(.INIT_FRAMES(INIT_FRAMES)) i_win (
    .aclk(aclk), .rst_n(rst_n), .frame_tick(frame_tick), .busy(init_busy));

  serctl_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_init_sync (
    .clk(sclk), .rst_n(rst_n), .d(init_busy), .q(s_init));

  serctl_sync #(.W(NSTAT*DATA_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_stat_sync (
    .clk(sclk), .rst_n(rst_n), .d(stat_i), .q(stat_s));

  // Serial-side write decode
  assign w_addr = word_addr(rx_word);
  assign wr_req = rx_done && !word_is_read(rx_word);
  assign wr_ctl = 32'(w_addr) < NCTRL;
  assign s_drop = wr_req && (s_init || s_busy);
  assign s_push = wr_req && !s_drop && wr_ctl;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)      wr_err <= 1'b0;
    else if (s_drop) wr_err <= 1'b1;
  end

  serctl_xfer #(.SYNC_STAGES(SYNC_STAGES)) i_xfer (
    .s_clk(sclk), .a_clk(aclk), .rst_n(rst_n), .s_push(s_push), .s_addr(w_addr),
    .s_data(word_data(rx_word)), .s_busy(s_busy), .a_upd(a_upd), .a_addr(a_addr),
    .a_data(a_data));

  for (genvar i = 0; i < NCTRL; i++) begin : g_reg
    always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)                            shadow[i] <= ctl_default(i);
      else if (s_push && w_addr == addr_t'(i)) shadow[i] <= word_data(rx_word);
    end

    always_ff @(posedge aclk or negedge rst_n) begin
      if (!rst_n)                           creg[i] <= ctl_default(i);
      else if (a_upd && a_addr == addr_t'(i)) creg[i] <= a_data;
    end

    assign ctrl_o[i*DATA_W +: DATA_W] = creg[i];
  end

  // Read mux: control shadow or synchronised status
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCTRL; i++)
      if (hdr_addr == addr_t'(i)) rdata = shadow[i];
    for (int j = 0; j < NSTAT; j++)
      if (hdr_addr == addr_t'(NCTRL + j)) rdata = stat_s[j*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/serctl_port_chk.sv
module serctl_port_chk
  import serctl_pkg::*;
#(
  parameter int unsigned NCTRL = 12
) (
  input logic                    aclk,
  input logic                    sclk,
  input logic                    rst_n,
  input logic                    ss_n,
  input logic                    miso,
  input logic                    frame_tick,
  input logic                    init_busy,
  input logic                    wr_err,
  input logic                    a_upd,
  input logic [NCTRL*DATA_W-1:0] ctrl_o
);
  // R7
  init_stays_low_chk: assert property (@(posedge aclk) disable iff (!rst_n)
    !init_busy |=> !init_busy);

  // R7
  init_ends_on_tick_chk: assert property (@(posedge aclk) disable iff (!rst_n)
    $fell(init_busy) |-> $past(frame_tick));

  // R3
  ctrl_hold_chk: assert property (@(posedge aclk) disable iff (!rst_n)
    !a_upd |=> $stable(ctrl_o));

  // R8
  no_update_in_window_chk: assert property (@(posedge aclk) disable iff (!rst_n)
    a_upd |-> !init_busy);

  // R8
  err_sticky_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    wr_err |=> wr_err);

  // R4
  miso_idle_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (ss_n && $past(ss_n)) |-> !miso);
endmodule

bind serctl_port serctl_port_chk #(.NCTRL(NCTRL)) i_chk (
  .aclk(aclk), .sclk(sclk), .rst_n(rst_n), .ss_n(ss_n), .miso(miso),
  .frame_tick(frame_tick), .init_busy(init_busy), .wr_err(wr_err),
  .a_upd(a_upd), .ctrl_o(ctrl_o));

// File: tb/test_serctl_port.sv
`timescale 1ns/1ps
module test_serctl_port;
  localparam int NCTRL = 12;
  localparam int NSTAT = 4;
  localparam int DW    = 10;

  logic aclk = 0, sclk = 0, rst_n = 0, frame_tick = 0, ss_n = 1, mosi = 0;
  logic [NSTAT*DW-1:0] stat_i = '0;
  logic [NCTRL*DW-1:0] ctrl_o;
  logic init_busy, miso, wr_err;
  int errors = 0, checks = 0;

  always #2.5 aclk = ~aclk;
  always #62  sclk = ~sclk;

  serctl_port i_serctl_port (
    .aclk(aclk), .rst_n(rst_n), .frame_tick(frame_tick), .stat_i(stat_i),
    .ctrl_o(ctrl_o), .init_busy(init_busy), .sclk(sclk), .ss_n(ss_n),
    .mosi(mosi), .miso(miso), .wr_err(wr_err));

  function automatic int dflt(int k); return k * 64 + 3; endfunction
  function automatic int wval(int k); return (k * 83 + 5) % 1024; endfunction
  function automatic logic [15:0] mkw(int a, bit rd, bit rsv, int d);
    return {a[3:0], rd, rsv, d[9:0]};
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] w, input int nbits,
                       output logic [9:0] rd, output logic [5:0] lead);
    rd = '0; lead = '0;
    for (int k = 0; k < nbits; k++) begin
      @(negedge sclk);
      ss_n = 0;
      mosi = (k < 16) ? w[15-k] : k[0];
      @(posedge sclk); #1;
      if (k < 6) lead[5-k] = miso;
      else if (k < 16) rd[15-k] = miso;
    end
    @(negedge sclk); ss_n = 1; mosi = 0;
    repeat (4) @(negedge sclk);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      @(negedge aclk); frame_tick = 1;
      @(negedge aclk); frame_tick = 0;
    end
  endtask

  task automatic check_ctrl(string req, int upto);
    for (int k = 0; k < NCTRL; k++)
      check(req, int'(ctrl_o[k*DW +: DW]), (k <= upto) ? wval(k) : dflt(k));
  endtask

  function automatic int stat_pat(int j, int s); return (j * 211 + s * 97 + 1) % 1024; endfunction

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge aclk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [9:0] rd; logic [5:0] lead;
    for (int j = 0; j < NSTAT; j++) stat_i[j*DW +: DW] = stat_pat(j, 0);
    repeat (3) @(negedge sclk);
    // R1: reset state
    for (int k = 0; k < NCTRL; k++) check("R1", int'(ctrl_o[k*DW +: DW]), dflt(k));
    check("R1 init_busy", init_busy, 1);
    check("R1 wr_err", wr_err, 0);
    check("R4 miso idle", miso, 0);
    @(negedge sclk); rst_n = 1;
    repeat (2) @(negedge sclk);

    // R1/R4: default readback during window; lead bits zero
    frame(mkw(5, 1, 0, 0), 16, rd, lead);
    check("R1 readback", rd, dflt(5));
    check("R4 lead", lead, 0);
    // R5: status read
    frame(mkw(14, 1, 1, 0), 16, rd, lead);
    check("R5", rd, stat_pat(2, 0));

    // R8: write during window dropped
    frame(mkw(3, 0, 0, 777), 16, rd, lead);
    check("R8 dropped", int'(ctrl_o[3*DW +: DW]), dflt(3));
    check("R8 err", wr_err, 1);

    // R7: window length
    ticks(19);
    @(negedge aclk);
    check("R7 busy", init_busy, 1);
    ticks(1);
    check("R7 end", init_busy, 0);
    repeat (4) @(negedge sclk);

    // R3/R2: sweep writes, reserved bit alternating
    for (int k = 0; k < NCTRL; k++) begin
      frame(mkw(k, 0, k[0], wval(k)), 16, rd, lead);
      check_ctrl("R3", k);
    end
    // R4: readback of every control register
    for (int k = 0; k < NCTRL; k++) begin
      frame(mkw(k, 1, 0, 0), 16, rd, lead);
      check("R4 readback", rd, wval(k));
      check("R4 lead", lead, 0);
    end
    // R5: two status patterns
    for (int s = 1; s < 3; s++) begin
      for (int j = 0; j < NSTAT; j++) stat_i[j*DW +: DW] = stat_pat(j, s);
      repeat (4) @(negedge sclk);
      for (int j = 0; j < NSTAT; j++) begin
        frame(mkw(NCTRL + j, 1, 0, 0), 16, rd, lead);
        check("R5", rd, stat_pat(j, s));
      end
    end
    // R6: write to status address ignored
    frame(mkw(13, 0, 0, 555), 16, rd, lead);
    check_ctrl("R6", NCTRL - 1);
    frame(mkw(13, 1, 0, 0), 16, rd, lead);
    check("R6 status", rd, stat_pat(1, 2));

    // R9: short frame has no effect
    frame(mkw(2, 0, 0, 999), 10, rd, lead);
    check_ctrl("R9 short", NCTRL - 1);
    // R9: bits after the 16th ignored
    frame(mkw(2, 0, 0, 321), 20, rd, lead);
    check("R9 long", int'(ctrl_o[2*DW +: DW]), 321);
    frame(mkw(2, 1, 0, 0), 20, rd, lead);
    check("R9 long readback", rd, 321);
    check("R8 sticky", wr_err, 1);
    summary();
  end
endmodule